// File: doc/BRIEF.md
# Channel-Status and User Block Collector

This block sits after a biphase-mark decoder in a digital audio receiver. For each decoded subframe it is given the subframe's preamble class and its channel-status (C) and user (U) bits. It gathers one C bit and one U bit per frame into two 192-bit blocks. Bit 0 of each block is the frame whose first subframe carries the block-start preamble. Frame position is set by that preamble, not by a free-running counter.

When the last frame of a block ends, both blocks are copied into output registers and a ready flag is raised. The flag stays high until the consumer acknowledges it. Bit 0 of the latched channel-status block is shown on its own pin as the consumer/professional indication.

The C bit of the second subframe in each frame is checked against the first. The channel-number field is left out of this check. Three sticky flags report problems: a channel-status mismatch, a block-start preamble that arrives before the block is full, and a block that completes while the previous one is still unacknowledged.

Top module: `chstat_block_collector`

## Requirements
- R1: During and directly after reset, both output blocks, the ready flag, the mode bit and all three sticky flags are 0.
- R2: The preamble class is coded on `sf_pre` as 2'b00 = block start, 2'b01 = first subframe of an ordinary frame, 2'b10 = second subframe, 2'b11 = none. The C bit of the first subframe of frame k (k = 0 for the block-start frame) is placed at `cs_block[k]`. Subframes seen before the first block-start preamble are ignored.
- R3: In the same way, the U bit of the first subframe of frame k is placed at `ud_block[k]`.
- R4: On the clock edge that accepts the second subframe of frame 191, both blocks are latched and `blk_ready` rises. Both are visible after that edge.
- R5: `pro_mode` equals bit 0 of the latched channel-status block.
- R6: `blk_ready` stays high until a cycle with `blk_ack` high clears it at the next edge. While it is high, the latched blocks change only when a new block completes.
- R7: If a block completes while `blk_ready` is high and `blk_ack` is low, `blk_overrun` is set and stays set, and the new block replaces the latched one.
- R8: If the C bits of the two subframes of a frame differ, `cs_mismatch` is set and stays set. This does not apply to frame indices from CHN_LO to CHN_HI (default 20 to 23), which are not compared.
- R9: If a block-start preamble arrives while a block is partly collected, `blk_error` is set and stays set. The partial block is dropped and collection restarts at bit 0.
- R10: After a block completes, subframes are ignored until the next block-start preamble. A run of 192 frames with no block-start preamble produces no ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_valid | input | 1 | One decoded subframe is present this cycle |
| sf_pre | input | 2 | Preamble class of the subframe |
| sf_cbit | input | 1 | Channel-status bit of the subframe |
| sf_ubit | input | 1 | User bit of the subframe |
| blk_ack | input | 1 | Consumer has taken the latched blocks |
| cs_block | output | 192 | Latched channel-status block, bit 0 first |
| ud_block | output | 192 | Latched user-data block, bit 0 first |
| blk_ready | output | 1 | A completed block is waiting |
| pro_mode | output | 1 | Bit 0 of the latched channel-status block |
| cs_mismatch | output | 1 | Sticky: C bits of the two subframes differed |
| blk_error | output | 1 | Sticky: block-start arrived before the block was full |
| blk_overrun | output | 1 | Sticky: block completed while ready was still high |

## Verification
The bench sends stray frames before the first block-start preamble. A design that counted those frames would place its bits at shifted positions. It sends a full block's worth of frames with no block start after a completion. A collector that wrapped on a counter would raise ready spuriously. It places a C disagreement inside the channel-number range and another outside it. A comparator that applied the exclusion range wrongly would flag the first or miss the second. It also restarts a block 50 frames in and completes a block while the previous one is unacknowledged. This catches a design that keeps stale partial bits, fails to set the error and overrun flags, or refuses to replace the held block.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [1:0] {
    PRE_BLK  = 2'b00,
    PRE_CHA  = 2'b01,
    PRE_CHB  = 2'b10,
    PRE_NONE = 2'b11
  } pre_t;
endpackage

// File: rtl/cbc_frame_tracker.sv
module cbc_frame_tracker #(
  parameter int N_FRAMES = 192,
  localparam int IDXW = $clog2(N_FRAMES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sf_valid,
  input  logic [1:0]      sf_pre,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic            cmp_en,
  output logic [IDXW-1:0] cmp_idx,
  output logic            blk_done,
  output logic            blk_error
);
  import cbc_pkg::*;
  localparam logic [IDXW-1:0] LAST = IDXW'(N_FRAMES - 1);

  logic            aligned_q;
  logic            in_a_q;
  logic [IDXW-1:0] idx_q;
  logic            err_q;
  logic            is_blk, is_cha, is_chb;

  always_comb begin
    is_blk   = sf_valid && (sf_pre == PRE_BLK);
    is_cha   = sf_valid && (sf_pre == PRE_CHA) && aligned_q;
    is_chb   = sf_valid && (sf_pre == PRE_CHB) && aligned_q && in_a_q;
    wr_en    = is_blk || is_cha;
    wr_idx   = is_blk ? '0 : idx_q;
    cmp_en   = is_chb;
    cmp_idx  = idx_q;
    blk_done = is_chb && (idx_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aligned_q <= 1'b0;
      in_a_q    <= 1'b0;
      idx_q     <= '0;
      err_q     <= 1'b0;
    end else if (is_blk) begin
      if (aligned_q && (idx_q != '0 || in_a_q)) err_q <= 1'b1;
      aligned_q <= 1'b1;
      in_a_q    <= 1'b1;
      idx_q     <= '0;
    end else if (is_cha) begin
      in_a_q <= 1'b1;
    end else if (is_chb) begin
      in_a_q <= 1'b0;
      if (idx_q == LAST) begin
        aligned_q <= 1'b0;
        idx_q     <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign blk_error = err_q;

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R9
  AST_BLK_RESTART: assert property (@(posedge clk) disable iff (rst)
    is_blk |=> (idx_q == '0 && in_a_q && aligned_q)); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> !aligned_q); // R10
endmodule

// File: rtl/cbc_bit_store.sv
module cbc_bit_store #(
  parameter int N_FRAMES = 192,
  localparam int IDXW = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDXW-1:0]     wr_idx,
  input  logic                wr_bit,
  input  logic                latch_en,
  output logic [N_FRAMES-1:0] blk_q
);
  logic [N_FRAMES-1:0] work_q;

  always_ff @(posedge clk) begin
    if (wr_en) work_q[wr_idx] <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (rst)           blk_q <= '0;
    else if (latch_en) blk_q <= work_q;
  end

  AST_LATCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(blk_q)); // R6
endmodule

// File: rtl/cbc_cs_compare.sv
module cbc_cs_compare #(
  parameter int N_FRAMES = 192,
  parameter int CHN_LO   = 20,
  parameter int CHN_HI   = 23,
  localparam int IDXW = $clog2(N_FRAMES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic            cap_bit,
  input  logic            cmp_en,
  input  logic [IDXW-1:0] cmp_idx,
  input  logic            cmp_bit,
  output logic            mismatch
);
  logic first_q;
  logic mis_q;
  logic excluded;

  always_comb excluded = (int'(cmp_idx) >= CHN_LO) && (int'(cmp_idx) <= CHN_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      if (cap_en) first_q <= cap_bit;
      if (cmp_en && !excluded && (cmp_bit != first_q)) mis_q <= 1'b1;
    end
  end

  assign mismatch = mis_q;

  AST_MIS_STICKY: assert property (@(posedge clk) disable iff (rst)
    mis_q |=> mis_q); // R8
  AST_MIS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!mis_q && !cmp_en) |=> !mis_q); // R8
endmodule

// File: rtl/chstat_block_collector.sv
module chstat_block_collector #(
  parameter int N_FRAMES = 192,
  parameter int CHN_LO   = 20,
  parameter int CHN_HI   = 23,
  localparam int IDXW = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sf_valid,
  input  logic [1:0]          sf_pre,
  input  logic                sf_cbit,
  input  logic                sf_ubit,
  input  logic                blk_ack,
  output logic [N_FRAMES-1:0] cs_block,
  output logic [N_FRAMES-1:0] ud_block,
  output logic                blk_ready,
  output logic                pro_mode,
  output logic                cs_mismatch,
  output logic                blk_error,
  output logic                blk_overrun
);
  logic            wr_en, cmp_en, done;
  logic [IDXW-1:0] wr_idx, cmp_idx;
  logic            ready_q, ovr_q;

  cbc_frame_tracker #(.N_FRAMES(N_FRAMES)) u_track (
    .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_pre(sf_pre),
    .wr_en(wr_en), .wr_idx(wr_idx), .cmp_en(cmp_en), .cmp_idx(cmp_idx),
    .blk_done(done), .blk_error(blk_error)
  );

  cbc_bit_store #(.N_FRAMES(N_FRAMES)) u_cs_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_bit(sf_cbit),
    .latch_en(done), .blk_q(cs_block)
  );

  cbc_bit_store #(.N_FRAMES(N_FRAMES)) u_ud_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_bit(sf_ubit),
    .latch_en(done), .blk_q(ud_block)
  );

  cbc_cs_compare #(.N_FRAMES(N_FRAMES), .CHN_LO(CHN_LO), .CHN_HI(CHN_HI)) u_cmp (
    .clk(clk), .rst(rst), .cap_en(wr_en), .cap_bit(sf_cbit),
    .cmp_en(cmp_en), .cmp_idx(cmp_idx), .cmp_bit(sf_cbit), .mismatch(cs_mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (done) begin
      if (ready_q && !blk_ack) ovr_q <= 1'b1;
      ready_q <= 1'b1;
    end else if (blk_ack) begin
      ready_q <= 1'b0;
    end
  end

  assign blk_ready   = ready_q;
  assign blk_overrun = ovr_q;
  assign pro_mode    = cs_block[0];

  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    done |=> blk_ready); // R4
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (blk_ready && !blk_ack && !done) |=> blk_ready); // R6
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (blk_ack && !done) |=> !blk_ready); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    blk_overrun |=> blk_overrun); // R7
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (done && blk_ready && !blk_ack) |=> blk_overrun); // R7
endmodule

// File: tb/test_chstat_block_collector.sv
module test_chstat_block_collector;
  localparam int N = 192;
  localparam logic [1:0] P_B = 2'b00, P_M = 2'b01, P_W = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sf_valid = 1'b0;
  logic [1:0] sf_pre = 2'b11;
  logic sf_cbit = 1'b0, sf_ubit = 1'b0, blk_ack = 1'b0;
  logic [N-1:0] cs_block, ud_block;
  logic blk_ready, pro_mode, cs_mismatch, blk_error, blk_overrun;

  always #10 clk = ~clk;

  chstat_block_collector i_chstat_block_collector (
    .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_pre(sf_pre),
    .sf_cbit(sf_cbit), .sf_ubit(sf_ubit), .blk_ack(blk_ack),
    .cs_block(cs_block), .ud_block(ud_block), .blk_ready(blk_ready),
    .pro_mode(pro_mode), .cs_mismatch(cs_mismatch), .blk_error(blk_error),
    .blk_overrun(blk_overrun)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural reference state
  logic [N-1:0] m_wc = '0, m_wu = '0, m_cs = '0, m_ud = '0;
  int m_idx = 0;
  bit m_al = 0, m_ina = 0, m_ca = 0, m_rdy = 0, m_ovr = 0, m_err = 0, m_mis = 0;

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    bit done = 0;
    if (sf_valid) begin
      if (sf_pre == P_B) begin
        if (m_al && (m_idx != 0 || m_ina)) m_err = 1;
        m_al = 1; m_idx = 0; m_ina = 1;
        m_wc[0] = sf_cbit; m_wu[0] = sf_ubit; m_ca = sf_cbit;
      end else if (sf_pre == P_M && m_al) begin
        m_wc[m_idx] = sf_cbit; m_wu[m_idx] = sf_ubit; m_ca = sf_cbit; m_ina = 1;
      end else if (sf_pre == P_W && m_al && m_ina) begin
        if (sf_cbit != m_ca && !(m_idx >= 20 && m_idx <= 23)) m_mis = 1;
        m_ina = 0;
        if (m_idx == N - 1) begin done = 1; m_al = 0; m_idx = 0; end
        else m_idx++;
      end
    end
    if (done) begin
      if (m_rdy && !blk_ack) m_ovr = 1;
      m_rdy = 1; m_cs = m_wc; m_ud = m_wu;
    end else if (blk_ack) m_rdy = 0;
  endtask

  task automatic compare_all();
    chk("R2 cs_block", cs_block, m_cs);
    chk("R3 ud_block", ud_block, m_ud);
    chk("R6 blk_ready", N'(blk_ready), N'(m_rdy));
    chk("R5 pro_mode", N'(pro_mode), N'(m_cs[0]));
    chk("R8 cs_mismatch", N'(cs_mismatch), N'(m_mis));
    chk("R9 blk_error", N'(blk_error), N'(m_err));
    chk("R7 blk_overrun", N'(blk_overrun), N'(m_ovr));
  endtask

  // called at a negedge: drive, let one edge pass, compare at next negedge
  task automatic step(bit v, logic [1:0] p, bit c, bit u, bit a);
    sf_valid = v; sf_pre = p; sf_cbit = c; sf_ubit = u; blk_ack = a;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  function automatic bit pat_c(int sel, int k);
    case (sel)
      0: return (k % 3) == 0;
      1: return (k % 7) == 2;
      default: return ((k * 5) % 11) < 4;
    endcase
  endfunction

  task automatic send_block(int nfr, int sel, int mis_idx, bit use_b);
    for (int k = 0; k < nfr; k++) begin
      bit c = pat_c(sel, k);
      bit u = ((k + sel) % 4) == 1;
      step(1, (k == 0 && use_b) ? P_B : P_M, c, u, 0);
      step(1, P_W, (k == mis_idx) ? !c : c, u, 0);
    end
  endtask

  function automatic logic [N-1:0] exp_cs(int sel);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = pat_c(sel, k);
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 cs_block", cs_block, '0);
    chk("R1 ud_block", ud_block, '0);
    chk("R1 flags", N'({blk_ready, pro_mode, cs_mismatch, blk_error, blk_overrun}), '0);

    // stray frames before any block start are ignored (R2)
    send_block(3, 2, -1, 0);
    send_block(N, 0, -1, 1);
    chk("R4 ready after last frame", N'(blk_ready), N'(1));
    chk("R2 block0 content", cs_block, exp_cs(0));
    chk("R5 pro bit one", N'(pro_mode), N'(1));

    repeat (5) step(0, 2'b11, 0, 0, 0);
    chk("R6 ready held", N'(blk_ready), N'(1));
    step(0, 2'b11, 0, 0, 1);
    chk("R6 ack clears", N'(blk_ready), N'(0));

    // R10: full block of frames with no block start gives no ready
    send_block(N, 1, -1, 0);
    chk("R10 no ready without block start", N'(blk_ready), N'(0));
    chk("R10 block kept", cs_block, exp_cs(0));

    // R8: disagreement inside channel-number range is not flagged
    send_block(N, 1, 21, 1);
    chk("R8 excluded range", N'(cs_mismatch), N'(0));
    chk("R5 pro bit zero", N'(pro_mode), N'(0));

    // R7: completion while still ready
    send_block(N, 2, -1, 1);
    chk("R7 overrun set", N'(blk_overrun), N'(1));
    chk("R7 block replaced", cs_block, exp_cs(2));
    step(0, 2'b11, 0, 0, 1);

    // R9: restart after 50 frames, then mismatch outside range (R8)
    send_block(50, 0, -1, 1);
    send_block(N, 1, 5, 1);
    chk("R9 error set", N'(blk_error), N'(1));
    chk("R9 partial discarded", cs_block, exp_cs(1));
    chk("R8 mismatch flagged", N'(cs_mismatch), N'(1));
    repeat (4) step(0, 2'b11, 0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule